// File: doc/BRIEF.md
# RX Flow-Control Threshold Unit

This unit watches the fill levels of one channel's receive and transmit FIFOs. It compares them against thresholds held in two small configuration bytes. One byte carries the halt and resume levels for hardware flow control. The other carries the transmit and receive trigger levels. Each threshold is a 4-bit nibble, and the level it stands for is the nibble times four, so a threshold can be 4, 8, 12 and so on up to 60. A nibble of zero turns that threshold off.

There are three outputs. Two are trigger flags: one says the transmit FIFO has drained below its level, and one says the receive FIFO has filled past its level. These flags are combinational from the registered configuration and the live counts. The third output is a registered flow-control halt signal with hysteresis. It asserts once the receive level reaches the halt level. It releases only when the receive level drops to the resume level or below. The FIFOs, the serial line and any software register decoding are outside this block. The block receives the counts (0 to 64) and write strobes carrying a data byte.

Top module: `fct_threshold_unit`

## Requirements
- R1: After a synchronous active-low reset, both configuration bytes are 0, `flow_halt` is 0 (resume), and both trigger flags are 0.
- R2: On a clock edge with `hyst_we` high, `cfg_data` is loaded into the flow-control byte. With `trig_we` high it is loaded into the trigger byte. A byte whose strobe is low keeps its value.
- R3: `tx_trig` is 1 exactly when the trigger byte's bits [3:0] are nonzero and `tx_count` is less than 4 times that nibble. It follows the counts in the same cycle.
- R4: `rx_trig` is 1 exactly when the trigger byte's bits [7:4] are nonzero and `rx_count` is greater than 4 times that nibble. It follows the counts in the same cycle.
- R5: With the flow-control byte's bits [3:0] (halt nibble) nonzero, `flow_halt` is 1 after any clock edge at which `rx_count` was at least 4 times the halt nibble. This takes priority over resume when the two levels overlap.
- R6: When the halt condition of R5 is false and `rx_count` is at most 4 times the flow-control byte's bits [7:4] (resume nibble), `flow_halt` is 0 after the edge.
- R7: When neither the halt condition nor the resume condition holds, `flow_halt` keeps its previous value across the edge.
- R8: With a halt nibble of 0, halting is disabled. `flow_halt` never rises, and if it was 1 it returns to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 7 | Current receive FIFO fill level, 0 to 64 |
| tx_count | input | 7 | Current transmit FIFO fill level, 0 to 64 |
| hyst_we | input | 1 | Load strobe for the flow-control byte (halt low nibble, resume high nibble) |
| trig_we | input | 1 | Load strobe for the trigger byte (transmit low nibble, receive high nibble) |
| cfg_data | input | 8 | Data byte for either strobe |
| rx_trig | output | 1 | Receive level above receive trigger |
| tx_trig | output | 1 | Transmit level below transmit trigger |
| flow_halt | output | 1 | Registered flow-control request: 1 halt, 0 resume |

## Verification
The bench sweeps the receive level up through the halt level and back down through the resume level. This exposes a design that releases as soon as the level falls below the halt level instead of holding across the gap, or that treats the levels as strict instead of inclusive. It also programs overlapping halt and resume levels, where a wrong priority makes the output toggle. It zeroes each nibble, where a missing disable check would fire a flag at count 0 or halt on an empty FIFO. Random counts and random configuration writes test the comparison boundaries at exactly 4 times each nibble, including the full count of 64, against an independent model.

// File: rtl/fct_pkg.sv
// Shared constants for the flow-control threshold unit.
// Assumes thresholds are nibbles scaled by a power of two.
package fct_pkg;
    localparam int NIB_W    = 4;  // width of one threshold field
    localparam int SCALE_SH = 2;  // threshold level = nibble << SCALE_SH
    localparam int CFG_W    = 2 * NIB_W;
endpackage

// File: rtl/fct_cfg_reg.sv
// Configuration byte register: loads d on a write strobe, else holds.
// Assumes a synchronous active-low reset clearing the byte to zero.
module fct_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold or load the configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(d));  // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> q == $past(q));  // R2
endmodule

// File: rtl/fct_level_cmp.sv
// Compares a FIFO count against a scaled nibble threshold.
// BELOW=1 flags count < level, BELOW=0 flags count > level.
// A zero nibble disables the flag. Purely combinational.
module fct_level_cmp
    import fct_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter bit BELOW = 1'b1
) (
    input  logic [NIB_W-1:0] nib,
    input  logic [CNT_W-1:0] count,
    output logic             flag
);
    logic [CNT_W-1:0] level;

    // Scale the nibble into a count-wide level.
    always_comb level = CNT_W'(nib) << SCALE_SH;

    generate
        if (BELOW) begin : g_below
            // Flag when the count is under the level.
            always_comb flag = (nib != '0) && (count < level);
        end else begin : g_above
            // Flag when the count is over the level.
            always_comb flag = (nib != '0) && (count > level);
        end
    endgenerate
endmodule

// File: rtl/fct_hyst.sv
// Hysteresis state for flow control: sets at or above the halt level,
// clears at or below the resume level, holds in between.
// Assumes halt has priority if the levels overlap, and a zero halt
// nibble disables halting. Reset state is resume (0).
module fct_hyst
    import fct_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [NIB_W-1:0] halt_nib,
    input  logic [NIB_W-1:0] resume_nib,
    output logic             halt_q
);
    logic [CNT_W-1:0] halt_lvl;
    logic [CNT_W-1:0] resume_lvl;
    logic             halt_en;
    logic             set_c;
    logic             clr_c;

    // Decode levels and the set/clear conditions.
    always_comb begin
        halt_lvl   = CNT_W'(halt_nib) << SCALE_SH;
        resume_lvl = CNT_W'(resume_nib) << SCALE_SH;
        halt_en    = (halt_nib != '0);
        set_c      = halt_en && (rx_count >= halt_lvl);
        clr_c      = !halt_en || (rx_count <= resume_lvl);
    end

    // Update the flow-control state.
    always_ff @(posedge clk) begin
        if (!rst_n)     halt_q <= 1'b0;
        else if (set_c) halt_q <= 1'b1;
        else if (clr_c) halt_q <= 1'b0;
    end

    AST_HALT_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_nib != '0 && rx_count >= halt_lvl) |=> halt_q);  // R5
    AST_RESUME_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_nib != '0 && rx_count < halt_lvl && rx_count <= resume_lvl) |=> !halt_q);  // R6
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_nib != '0 && rx_count < halt_lvl && rx_count > resume_lvl && $past(rst_n))
        |=> halt_q == $past(halt_q));  // R7
    AST_HALT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_nib == '0) |=> !halt_q);  // R8
endmodule

// File: rtl/fct_threshold_unit.sv
// Top of the flow-control threshold unit for one channel.
// Holds two configuration bytes, derives transmit/receive trigger
// flags combinationally, and keeps a registered halt output with
// hysteresis. Assumes counts range 0..64 and sync active-low reset.
module fct_threshold_unit
    import fct_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             hyst_we,
    input  logic             trig_we,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             rx_trig,
    output logic             tx_trig,
    output logic             flow_halt
);
    logic [CFG_W-1:0] hyst_cfg;
    logic [CFG_W-1:0] trig_cfg;

    fct_cfg_reg #(.W(CFG_W)) u_hyst_cfg (
        .clk(clk), .rst_n(rst_n), .we(hyst_we), .d(cfg_data), .q(hyst_cfg)
    );
    fct_cfg_reg #(.W(CFG_W)) u_trig_cfg (
        .clk(clk), .rst_n(rst_n), .we(trig_we), .d(cfg_data), .q(trig_cfg)
    );

    fct_level_cmp #(.CNT_W(CNT_W), .BELOW(1'b1)) u_tx_cmp (
        .nib(trig_cfg[NIB_W-1:0]), .count(tx_count), .flag(tx_trig)
    );
    fct_level_cmp #(.CNT_W(CNT_W), .BELOW(1'b0)) u_rx_cmp (
        .nib(trig_cfg[CFG_W-1:NIB_W]), .count(rx_count), .flag(rx_trig)
    );

    fct_hyst #(.CNT_W(CNT_W)) u_hyst (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count),
        .halt_nib(hyst_cfg[NIB_W-1:0]), .resume_nib(hyst_cfg[CFG_W-1:NIB_W]),
        .halt_q(flow_halt)
    );

    AST_RESET_RESUME: assert property (@(posedge clk)
        !rst_n |=> (!flow_halt && !tx_trig && !rx_trig));  // R1
    AST_TX_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trig |-> (tx_count < (CNT_W'(trig_cfg[NIB_W-1:0]) << SCALE_SH)));  // R3
    AST_RX_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trig |-> (rx_count > (CNT_W'(trig_cfg[CFG_W-1:NIB_W]) << SCALE_SH)));  // R4
endmodule

// File: tb/fct_threshold_unit_bench.sv
module fct_threshold_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_count = '0;
    logic [6:0] tx_count = '0;
    logic       hyst_we = 1'b0;
    logic       trig_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       rx_trig, tx_trig, flow_halt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0] m_hyst = '0;
    logic [7:0] m_trig = '0;
    logic       m_halt = 1'b0;

    fct_threshold_unit u_fct_threshold_unit (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .hyst_we(hyst_we), .trig_we(trig_we), .cfg_data(cfg_data),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .flow_halt(flow_halt)
    );

    always #2 clk = ~clk;

    function automatic logic exp_tx(input logic [7:0] t, input int cnt);
        return (t[3:0] != 0) && (cnt < 4 * int'(t[3:0]));
    endfunction

    function automatic logic exp_rx(input logic [7:0] t, input int cnt);
        return (t[7:4] != 0) && (cnt > 4 * int'(t[7:4]));
    endfunction

    function automatic logic exp_halt(input logic [7:0] h, input int cnt, input logic cur);
        if (h[3:0] == 0) return 1'b0;
        if (cnt >= 4 * int'(h[3:0])) return 1'b1;
        if (cnt <= 4 * int'(h[7:4])) return 1'b0;
        return cur;
    endfunction

    function automatic string halt_req(input logic [7:0] h, input int cnt);
        if (h[3:0] == 0) return "R8";
        if (cnt >= 4 * int'(h[3:0])) return "R5";
        if (cnt <= 4 * int'(h[7:4])) return "R6";
        return "R7";
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    string pend_req = "R1";

    // One cycle: check registered state, drive inputs, check flags, advance model.
    task automatic cycle(input int rx, input int tx, input bit hw, input bit tw, input logic [7:0] d);
        @(negedge clk);
        check(flow_halt, m_halt, pend_req, "flow_halt");
        rx_count = 7'(rx); tx_count = 7'(tx);
        hyst_we = hw; trig_we = tw; cfg_data = d;
        #1;
        check(tx_trig, exp_tx(m_trig, tx), "R3", "tx_trig");
        check(rx_trig, exp_rx(m_trig, rx), "R4", "rx_trig");
        pend_req = halt_req(m_hyst, rx);
        m_halt = exp_halt(m_hyst, rx, m_halt);
        if (hw) begin m_hyst = d; pend_req = {pend_req, "/R2"}; end
        if (tw) m_trig = d;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // Reset state (R1)
        rx_count = 7'd64; tx_count = 7'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(flow_halt, 1'b0, "R1", "reset flow_halt");
        check(tx_trig, 1'b0, "R1", "reset tx_trig");
        check(rx_trig, 1'b0, "R1", "reset rx_trig");
        rst_n = 1'b1;
        // Zero config: halting disabled even at full (R8), flags off (R3/R4)
        cycle(64, 0, 0, 0, 8'h00);
        cycle(64, 0, 0, 0, 8'h00);
        // Program halt=24 resume=8 (R2), triggers tx=16 rx=32
        cycle(0, 0, 1, 0, 8'h26);
        cycle(0, 0, 0, 1, 8'h84);
        // Ramp up through halt, down through resume (R5, R7, R6)
        for (int i = 0; i <= 40; i++) cycle(i, i, 0, 0, 8'h00);
        for (int i = 40; i >= 0; i--) cycle(i, 64 - i, 0, 0, 8'h00);
        // Overlap: halt=8 resume=32, halt wins (R5)
        cycle(20, 0, 1, 0, 8'h82);
        for (int i = 0; i < 6; i++) cycle(8 + i * 4, 0, 0, 0, 8'h00);
        // Halted then halt disabled: release next edge (R8)
        cycle(60, 0, 1, 0, 8'h0F);
        cycle(60, 0, 0, 0, 8'h00);
        cycle(60, 0, 1, 0, 8'hF0);
        cycle(60, 0, 0, 0, 8'h00);
        cycle(64, 0, 0, 0, 8'h00);
        // Max levels: tx=60 rx=60
        cycle(64, 59, 0, 1, 8'hFF);
        cycle(61, 60, 0, 0, 8'h00);
        cycle(60, 64, 0, 0, 8'h00);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 15);
            cycle($urandom_range(0, 64), $urandom_range(0, 64),
                  r == 0, r == 1, 8'($urandom_range(0, 255)));
        end
        cycle(0, 0, 0, 0, 8'h00);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule